// File: doc/BRIEF.md
# Debug Access Port Protection Filter

This block sits on the path from a serial-wire debug port to four access ports. Two of them are memory-bus ports, one for the application domain and one for the network domain. The other two are control ports, again one for each domain. For every debugger request the filter decides whether the transfer may reach its access port. It makes that decision from protection settings that it captures from non-volatile configuration pins while reset is held.

A request that is refused is never forwarded. It is answered with an error flag one cycle later. An erase-all request that is refused simply produces no erase permit. Each domain has its own whole-port protection and its own erase lock. The application domain also has a secure-only protection that refuses secure transfers and lets non-secure transfers through. The network domain has no secure-only setting.

Erase permits come from two sources: the control port of the domain, or the flash controller's own erase-all request for that domain. Both are gated by the same erase lock.

Top module: `dap_guard`

## Requirements
- R1: The five protection settings are captured on every clock edge at which `rst_n` is low and hold their last captured value after reset is released; changes on the configuration pins after release have no effect on any output.
- R2: With application full protection captured, every request with `req_port` = 0 gives `rsp_err` = 1 and `fwd_valid[0]` = 0 on the next edge.
- R3: With application secure-only protection captured and full protection clear, a request on port 0 with `req_secure` = 1 is refused with `rsp_err`, and one with `req_secure` = 0 is forwarded.
- R4: With network full protection captured, every request with `req_port` = 1 gives `rsp_err` = 1 and `fwd_valid[1]` = 0 on the next edge.
- R5: The network domain has no secure-only setting: with network full protection clear, secure requests on port 1 are forwarded.
- R6: Requests with `req_port` = 2 (application control) or 3 (network control) are always forwarded and never flagged with `rsp_err`, whatever protection is captured.
- R7: `erase_ok_app` is 1 on the edge after a cycle in which the application erase lock is clear and either `nvm_erase_app` = 1 or a valid request on port 2 carries `req_erase` = 1; with the lock set it stays 0.
- R8: `erase_ok_net` follows the same rule using the network erase lock, `nvm_erase_net` and port 3.
- R9: A forwarded request sets only bit `req_port` of `fwd_valid`, copies `req_addr` to `fwd_addr` and `req_secure` to `fwd_secure`, with `rsp_err` = 0, on the next edge; with no forward `fwd_addr` and `fwd_secure` are 0.
- R10: While `rst_n` is low (synchronous), all outputs are 0 on the next edge.
- R11: A cycle with `req_valid` = 0 forwards nothing and raises no error; `req_erase` on ports 0 and 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; protection capture window |
| cfg_app_full | input | 1 | Application full protection from configuration |
| cfg_app_secure_only | input | 1 | Application secure-only protection from configuration |
| cfg_app_erase_lock | input | 1 | Application erase lock from configuration |
| cfg_net_full | input | 1 | Network full protection from configuration |
| cfg_net_erase_lock | input | 1 | Network erase lock from configuration |
| req_valid | input | 1 | Debugger request present this cycle |
| req_port | input | 2 | Target access port: 0 app memory, 1 net memory, 2 app control, 3 net control |
| req_secure | input | 1 | Request is a secure transfer |
| req_erase | input | 1 | Request is an erase-all command (meaningful on control ports) |
| req_addr | input | ADDR_W | Request address |
| nvm_erase_app | input | 1 | Flash controller erase-all request, application domain |
| nvm_erase_net | input | 1 | Flash controller erase-all request, network domain |
| fwd_valid | output | 4 | One-hot forward strobe, one bit per access port |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_secure | output | 1 | Forwarded secure attribute |
| rsp_err | output | 1 | Error response for a refused request |
| erase_ok_app | output | 1 | Erase-all permit, application domain |
| erase_ok_net | output | 1 | Erase-all permit, network domain |

## Verification
Every output is registered, so each result appears on the first rising edge after the cycle in which its request or erase input was present. The captured settings take effect from the edge on which reset is sampled low. The reference model computes the expected outputs at each rising edge from the inputs then present and its own copy of the captured settings. All outputs are compared at the following falling edge, so every comparison looks at exactly the edge its stimulus is due on. After each release the configuration pins are inverted, so every later comparison also shows that the pins are no longer watched.

// File: rtl/dap_guard_pkg.sv
package dap_guard_pkg;

   localparam int N_DOM    = 2;
   localparam int N_AP     = 2 * N_DOM;
   localparam int AP_SEL_W = $clog2(N_AP);

   localparam int DOM_APP = 0;
   localparam int DOM_NET = 1;

   // Per-domain protection captured at reset
   typedef struct packed {
      logic full;
      logic sec_only;
      logic erase_lock;
   } dom_prot_t;

   // Ports below N_DOM are memory ports; port p belongs to domain p % N_DOM
   function automatic int ap_domain(input int ap);
      return ap % N_DOM;
   endfunction

   function automatic bit ap_is_mem(input int ap);
      return ap < N_DOM;
   endfunction

endpackage

// File: rtl/dap_prot_latch.sv
module dap_prot_latch
   import dap_guard_pkg::*;
#(
   parameter bit HAS_SEC = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_full,
   input  logic      cfg_sec,
   input  logic      cfg_erase,
   output dom_prot_t prot
);

   logic sec_in;

   // A domain built without secure-only protection never captures it
   assign sec_in = HAS_SEC ? cfg_sec : 1'b0;

   // Capture while reset is sampled low, hold afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot <= {cfg_full, sec_in, cfg_erase};
      end
   end

endmodule

// File: rtl/dap_port_gate.sv
module dap_port_gate
   import dap_guard_pkg::*;
#(
   parameter int AP_ID  = 0,
   parameter bit IS_MEM = 1'b1
) (
   input  logic                req_valid,
   input  logic [AP_SEL_W-1:0] req_sel,
   input  logic                req_secure,
   input  logic                req_erase,
   input  logic                blk_full,
   input  logic                blk_sec,
   output logic                pass,
   output logic                deny,
   output logic                erase_req
);

   localparam logic [AP_SEL_W-1:0] MY_SEL = AP_SEL_W'(AP_ID);

   logic hit;
   logic refuse;

   if (AP_ID < 0 || AP_ID >= N_AP) begin : g_bad_id
      $error("dap_port_gate: AP_ID out of range");
   end

   assign hit = req_valid && (req_sel == MY_SEL);

   // Memory ports obey full and secure-only protection; control ports never refuse
   assign refuse    = IS_MEM ? (blk_full | (blk_sec & req_secure)) : 1'b0;
   assign deny      = hit & refuse;
   assign pass      = hit & ~refuse;
   // Only a control port carries an erase-all command
   assign erase_req = IS_MEM ? 1'b0 : (hit & req_erase);

endmodule

// File: rtl/dap_erase_gate.sv
module dap_erase_gate
   import dap_guard_pkg::*;
#(
   parameter int DOM = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lock,
   input  logic [N_AP-1:0] port_erase,
   input  logic            nvm_erase,
   output logic            erase_ok
);

   logic any_port;

   if (DOM < 0 || DOM >= N_DOM) begin : g_bad_dom
      $error("dap_erase_gate: DOM out of range");
   end

   always_comb begin
      any_port = 1'b0;
      for (int p = 0; p < N_AP; p++) begin
         if (ap_domain(p) == DOM) begin
            any_port = any_port | port_erase[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         erase_ok <= 1'b0;
      end else begin
         erase_ok <= ~lock & (any_port | nvm_erase);
      end
   end

endmodule

// File: rtl/dap_guard.sv
module dap_guard
   import dap_guard_pkg::*;
#(
   parameter int             ADDR_W     = 32,
   parameter bit [N_DOM-1:0] DOM_SEC_EN = 2'b01
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_app_full,
   input  logic                cfg_app_secure_only,
   input  logic                cfg_app_erase_lock,
   input  logic                cfg_net_full,
   input  logic                cfg_net_erase_lock,
   input  logic                req_valid,
   input  logic [AP_SEL_W-1:0] req_port,
   input  logic                req_secure,
   input  logic                req_erase,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                nvm_erase_app,
   input  logic                nvm_erase_net,
   output logic [N_AP-1:0]     fwd_valid,
   output logic [ADDR_W-1:0]   fwd_addr,
   output logic                fwd_secure,
   output logic                rsp_err,
   output logic                erase_ok_app,
   output logic                erase_ok_net
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("dap_guard: ADDR_W must be at least 1");
   end
   if (N_AP != 2 * N_DOM) begin : g_bad_map
      $error("dap_guard: one memory and one control port per domain expected");
   end

   logic [N_DOM-1:0] cfg_full_v;
   logic [N_DOM-1:0] cfg_sec_v;
   logic [N_DOM-1:0] cfg_lock_v;
   logic [N_DOM-1:0] nvm_v;
   logic [N_DOM-1:0] erase_ok_v;

   assign cfg_full_v = {cfg_net_full, cfg_app_full};
   assign cfg_sec_v  = {1'b0, cfg_app_secure_only};
   assign cfg_lock_v = {cfg_net_erase_lock, cfg_app_erase_lock};
   assign nvm_v      = {nvm_erase_net, nvm_erase_app};

   dom_prot_t [N_DOM-1:0] prot_q;

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      dap_prot_latch #(
         .HAS_SEC (DOM_SEC_EN[d])
      ) u_latch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_full  (cfg_full_v[d]),
         .cfg_sec   (cfg_sec_v[d]),
         .cfg_erase (cfg_lock_v[d]),
         .prot      (prot_q[d])
      );
   end

   logic [N_AP-1:0] pass_v;
   logic [N_AP-1:0] deny_v;
   logic [N_AP-1:0] erase_v;

   for (genvar p = 0; p < N_AP; p++) begin : g_port
      dap_port_gate #(
         .AP_ID  (p),
         .IS_MEM (ap_is_mem(p))
      ) u_gate (
         .req_valid  (req_valid),
         .req_sel    (req_port),
         .req_secure (req_secure),
         .req_erase  (req_erase),
         .blk_full   (prot_q[ap_domain(p)].full),
         .blk_sec    (prot_q[ap_domain(p)].sec_only),
         .pass       (pass_v[p]),
         .deny       (deny_v[p]),
         .erase_req  (erase_v[p])
      );
   end

   for (genvar d = 0; d < N_DOM; d++) begin : g_erase
      dap_erase_gate #(
         .DOM (d)
      ) u_erase (
         .clk        (clk),
         .rst_n      (rst_n),
         .lock       (prot_q[d].erase_lock),
         .port_erase (erase_v),
         .nvm_erase  (nvm_v[d]),
         .erase_ok   (erase_ok_v[d])
      );
   end

   assign erase_ok_app = erase_ok_v[DOM_APP];
   assign erase_ok_net = erase_ok_v[DOM_NET];

   logic any_pass;
   assign any_pass = |pass_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid  <= '0;
         fwd_addr   <= '0;
         fwd_secure <= 1'b0;
         rsp_err    <= 1'b0;
      end else begin
         fwd_valid  <= pass_v;
         fwd_addr   <= any_pass ? req_addr : '0;
         fwd_secure <= any_pass & req_secure;
         rsp_err    <= |deny_v;
      end
   end

endmodule

// File: rtl/dap_guard_chk.sv
module dap_guard_chk
   import dap_guard_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [AP_SEL_W-1:0] req_port,
   input logic                req_secure,
   input logic [N_AP-1:0]     fwd_valid,
   input logic                rsp_err,
   input logic                erase_ok_app,
   input logic                erase_ok_net,
   input dom_prot_t           prot_app,
   input dom_prot_t           prot_net
);

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n) rst_n && $past(rst_n) |-> $stable(prot_app) && $stable(prot_net)); // R1
   AST_ERR_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> fwd_valid == '0); // R2
   AST_APP_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_port == 2'd0 && prot_app.full |=> rsp_err && !fwd_valid[0]); // R2
   AST_APP_SEC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_port == 2'd0 && prot_app.sec_only && req_secure |=> rsp_err && !fwd_valid[0]); // R3
   AST_APP_NONSEC_PASS: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_port == 2'd0 && !prot_app.full && !req_secure |=> fwd_valid[0] && !rsp_err); // R3
   AST_NET_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_port == 2'd1 && prot_net.full |=> rsp_err && !fwd_valid[1]); // R4
   AST_NET_NO_SEC: assert property (@(posedge clk) disable iff (!rst_n) !prot_net.sec_only); // R5
   AST_NET_SEC_PASS: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_port == 2'd1 && !prot_net.full |=> fwd_valid[1] && !rsp_err); // R5
   AST_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_port[1] |=> !rsp_err && $countones(fwd_valid) == 1); // R6
   AST_APP_ERASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) prot_app.erase_lock |-> !erase_ok_app); // R7
   AST_NET_ERASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) prot_net.erase_lock |-> !erase_ok_net); // R8
   AST_ONEHOT_FWD: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fwd_valid)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> fwd_valid == '0 && !rsp_err); // R11

endmodule

bind dap_guard dap_guard_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_port     (req_port),
   .req_secure   (req_secure),
   .fwd_valid    (fwd_valid),
   .rsp_err      (rsp_err),
   .erase_ok_app (erase_ok_app),
   .erase_ok_net (erase_ok_net),
   .prot_app     (prot_q[0]),
   .prot_net     (prot_q[1])
);

// File: tb/dap_guard_tb.sv
module dap_guard_tb;
   import dap_guard_pkg::*;

   localparam int AW = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cfg_app_full = 1'b0, cfg_app_secure_only = 1'b0, cfg_app_erase_lock = 1'b0;
   logic          cfg_net_full = 1'b0, cfg_net_erase_lock = 1'b0;
   logic          req_valid = 1'b0, req_secure = 1'b0, req_erase = 1'b0;
   logic [1:0]    req_port = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic          nvm_erase_app = 1'b0, nvm_erase_net = 1'b0;
   logic [3:0]    fwd_valid;
   logic [AW-1:0] fwd_addr;
   logic          fwd_secure, rsp_err, erase_ok_app, erase_ok_net;

   dap_guard #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_app_full(cfg_app_full), .cfg_app_secure_only(cfg_app_secure_only),
      .cfg_app_erase_lock(cfg_app_erase_lock), .cfg_net_full(cfg_net_full),
      .cfg_net_erase_lock(cfg_net_erase_lock),
      .req_valid(req_valid), .req_port(req_port), .req_secure(req_secure),
      .req_erase(req_erase), .req_addr(req_addr),
      .nvm_erase_app(nvm_erase_app), .nvm_erase_net(nvm_erase_net),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_secure(fwd_secure),
      .rsp_err(rsp_err), .erase_ok_app(erase_ok_app), .erase_ok_net(erase_ok_net)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   // Behavioural reference: captured settings and expected outputs
   bit m_af, m_as, m_al, m_nf, m_nl;
   bit armed = 1'b0;
   bit blk, pins_moved;
   int p;
   bit [3:0]    e_fwd;
   bit [AW-1:0] e_addr;
   bit          e_sec, e_err, e_ea, e_en;
   string       t_main, t_ea, t_en, sfx;

   always @(posedge clk) begin
      armed = 1'b1;
      if (!rst_n) begin
         m_af = cfg_app_full; m_as = cfg_app_secure_only; m_al = cfg_app_erase_lock;
         m_nf = cfg_net_full; m_nl = cfg_net_erase_lock;
         e_fwd = '0; e_addr = '0; e_sec = 0; e_err = 0; e_ea = 0; e_en = 0;
         t_main = "R10"; t_ea = "R10"; t_en = "R10";
         pins_moved = 1'b0;
      end else begin
         p   = int'(req_port);
         blk = req_valid && ((p == 0 && (m_af || (m_as && req_secure))) || (p == 1 && m_nf));
         e_err  = blk;
         e_fwd  = (req_valid && !blk) ? 4'(1 << p) : 4'd0;
         e_addr = (e_fwd != 0) ? req_addr : '0;
         e_sec  = (e_fwd != 0) && req_secure;
         e_ea   = !m_al && (nvm_erase_app || (req_valid && p == 2 && req_erase));
         e_en   = !m_nl && (nvm_erase_net || (req_valid && p == 3 && req_erase));
         t_ea = "R7"; t_en = "R8";
         if (!req_valid)              t_main = "R11";
         else if (p == 0 && m_af)     t_main = "R2";
         else if (p == 0)             t_main = (m_as || !req_secure) ? "R3" : "R9";
         else if (p == 1 && m_nf)     t_main = "R4";
         else if (p == 1)             t_main = req_secure ? "R5" : "R9";
         else                         t_main = "R6";
         pins_moved = (cfg_app_full != m_af) || (cfg_app_secure_only != m_as) ||
                      (cfg_app_erase_lock != m_al) || (cfg_net_full != m_nf) ||
                      (cfg_net_erase_lock != m_nl);
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (armed && !done) begin
         sfx = pins_moved ? " (R1 pins moved)" : "";
         chk({t_main, " fwd_valid", sfx}, 64'(fwd_valid), 64'(e_fwd));
         chk({t_main, " rsp_err", sfx}, 64'(rsp_err), 64'(e_err));
         chk({"R9 fwd_addr", sfx}, 64'(fwd_addr), 64'(e_addr));
         chk({"R9 fwd_secure", sfx}, 64'(fwd_secure), 64'(e_sec));
         chk({t_ea, " erase_ok_app", sfx}, 64'(erase_ok_app), 64'(e_ea));
         chk({t_en, " erase_ok_net", sfx}, 64'(erase_ok_net), 64'(e_en));
      end
   end

   // Watchdog: a hung run is a failure and still reports
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // Every combination of the five settings (R1..R8)
      for (int c = 0; c < 32; c++) begin
         @(negedge clk);
         rst_n = 1'b0;
         req_valid = 1'b0; nvm_erase_app = 1'b0; nvm_erase_net = 1'b0;
         {cfg_app_full, cfg_app_secure_only, cfg_app_erase_lock, cfg_net_full, cfg_net_erase_lock} = 5'(c);
         repeat (3) @(negedge clk);   // R10 outputs held at zero
         rst_n = 1'b1;
         @(negedge clk);
         // R1: pins change after release, captured settings must not
         {cfg_app_full, cfg_app_secure_only, cfg_app_erase_lock, cfg_net_full, cfg_net_erase_lock} = ~5'(c);
         for (int pt = 0; pt < 4; pt++) begin
            for (int s = 0; s < 2; s++) begin
               for (int e = 0; e < 2; e++) begin
                  for (int n = 0; n < 4; n++) begin
                     @(negedge clk);
                     req_valid  = 1'b1;
                     req_port   = 2'(pt);
                     req_secure = s[0];
                     req_erase  = e[0];
                     nvm_erase_app = n[0];
                     nvm_erase_net = n[1];
                     req_addr = AW'(32'hA500_0000 ^ (c << 14) ^ (pt << 9) ^ (s << 5) ^ (e << 3) ^ n);
                  end
               end
            end
            // R11: idle cycle with erase strobes asserted on the request side
            @(negedge clk);
            req_valid = 1'b0; req_erase = 1'b1; nvm_erase_app = 1'b0; nvm_erase_net = 1'b0;
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule